// File: doc/BRIEF.md
# Floating-Point Status and Exception Accumulator

This block keeps the status word and the control word of a coprocessor-style floating-point unit. Each time the arithmetic datapath finishes an operation, it presents a one-cycle strobe. With the strobe it gives the sign of the result, a class code for the result, and the eight exception flags raised by that operation. In that cycle the block rebuilds the four condition-code bits from the sign and the class. It replaces the per-operation exception byte with the new flags. It ORs a summary of those flags into five sticky accrued bits.

A trap request is driven whenever an exception flag that is present in the status word is also enabled in the matching byte of the control word. The trap request follows the registers and is visible one cycle after the change that caused it. Software can write either register through one shared data bus. Reserved bit positions are always forced to zero. A status write overrides a result update in the same cycle.

Top module: `fpstat_accum`

## Requirements
- R1: Reset (asynchronous assert of `rst_n` low) clears both registers to zero and drives `trap_req` low. Updates resume two clocks after `rst_n` rises.
- R2: On a result update the condition nibble at status bits 27:24 is cleared, then refilled. N (bit 27) takes the result sign. Z (bit 26) is set for class 1 (zero), I (bit 25) for class 2 (infinity), and NAN (bit 24) for classes 3 and 4. Class 0 (ordinary number) and codes 5..7 set no class bit.
- R3: A class 4 (signalling NaN) result sets both NAN (bit 24) and the signalling-NaN exception flag (bit 14). A class 3 (quiet NaN) result sets NAN only.
- R4: On a result update the exception byte (bits 15:8) is replaced by `res_exc`, plus bit 14 for a signalling NaN. Its order from bit 15 down is: branch-unordered, signalling NaN, operand error, overflow, underflow, divide-by-zero, inexact-rounding, inexact-input. The quotient byte (bits 23:16) is left unchanged.
- R5: Accrued invalid (bit 7) is set by any of branch-unordered, signalling NaN or operand error. Accrued overflow (bit 6) is set by overflow. Accrued divide-by-zero (bit 4) is set by divide-by-zero.
- R6: Accrued underflow (bit 5) is set only when underflow and inexact-rounding are both in the new exception byte.
- R7: Accrued inexact (bit 3) is set by inexact-input, inexact-rounding or overflow.
- R8: Accrued bits are sticky: a result update never clears any of bits 7:3.
- R9: `trap_req` is high exactly when the status exception byte ANDed with control bits 15:8 is nonzero. It is visible in the cycle after the strobe or write.
- R10: A control write stores `wr_data & 0x0000FFF0`.
- R11: A status write stores `wr_data & 0x0FFFFFF8`.
- R12: A status write in the same cycle as a result strobe wins, and the result is dropped. A control write in the same cycle as a result strobe takes effect together with the result update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| res_vld | input | 1 | Result-complete strobe |
| res_sign | input | 1 | Result sign, 1 = negative |
| res_class | input | 3 | 0 number, 1 zero, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| res_exc | input | 8 | Exception flags raised by the operation |
| cr_wr | input | 1 | Software write to the control register |
| sr_wr | input | 1 | Software write to the status register |
| wr_data | input | 32 | Software write data |
| ctl_reg | output | 32 | Control register contents |
| sts_reg | output | 32 | Status register contents |
| trap_req | output | 1 | Enabled exception pending |

## Verification
The hardest state to reach is an update that must both clear and preserve fields of a status word that is already populated. The condition bits, quotient byte, exception byte and accrued bits all need distinct non-zero values at once, and only a software write can create them. Each table vector therefore first seeds the status word through a status write and then applies a result. This exposes a lost quotient byte, an uncleared exception byte or a dropped sticky bit. Write collisions with the strobe are produced by driving both inputs in the same cycle.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned CC_W    = 4;
  localparam int unsigned EXC_W   = 8;
  localparam int unsigned ACC_W   = 5;
  localparam int unsigned CLS_W   = 3;

  // field positions in the status word
  localparam int unsigned CC_LSB  = 24;
  localparam int unsigned EXC_LSB = 8;
  localparam int unsigned ACC_LSB = 3;

  // condition nibble
  localparam int unsigned CC_N    = 3;
  localparam int unsigned CC_Z    = 2;
  localparam int unsigned CC_I    = 1;
  localparam int unsigned CC_NAN  = 0;

  // exception byte
  localparam int unsigned EX_BSUN  = 7;
  localparam int unsigned EX_SNAN  = 6;
  localparam int unsigned EX_OPERR = 5;
  localparam int unsigned EX_OVFL  = 4;
  localparam int unsigned EX_UNFL  = 3;
  localparam int unsigned EX_DZ    = 2;
  localparam int unsigned EX_INEX2 = 1;
  localparam int unsigned EX_INEX1 = 0;

  // accrued field
  localparam int unsigned AC_IOP  = 4;
  localparam int unsigned AC_OVFL = 3;
  localparam int unsigned AC_UNFL = 2;
  localparam int unsigned AC_DZ   = 1;
  localparam int unsigned AC_INEX = 0;

  typedef enum logic [CLS_W-1:0] {
    CLS_NUM  = 3'd0,
    CLS_ZERO = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } res_class_e;
endpackage

// File: rtl/fpstat_cc_gen.sv
module fpstat_cc_gen
  import fpstat_pkg::*;
(
  input  logic             sign_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic [CC_W-1:0]  cc_o,
  output logic             snan_o
);
  always_comb begin
    cc_o       = '0;
    cc_o[CC_N] = sign_i;
    snan_o     = 1'b0;
    case (res_class_e'(cls_i))
      CLS_SNAN: begin
        cc_o[CC_NAN] = 1'b1;
        snan_o       = 1'b1;
      end
      CLS_QNAN: cc_o[CC_NAN] = 1'b1;
      CLS_ZERO: cc_o[CC_Z]   = 1'b1;
      CLS_INF:  cc_o[CC_I]   = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/fpstat_accrue.sv
module fpstat_accrue
  import fpstat_pkg::*;
(
  input  logic [EXC_W-1:0] exc_i,
  output logic [ACC_W-1:0] acc_set_o
);
  always_comb begin
    acc_set_o          = '0;
    acc_set_o[AC_IOP]  = exc_i[EX_BSUN] | exc_i[EX_SNAN] | exc_i[EX_OPERR];
    acc_set_o[AC_OVFL] = exc_i[EX_OVFL];
    acc_set_o[AC_UNFL] = exc_i[EX_UNFL] & exc_i[EX_INEX2];
    acc_set_o[AC_DZ]   = exc_i[EX_DZ];
    acc_set_o[AC_INEX] = exc_i[EX_INEX1] | exc_i[EX_INEX2] | exc_i[EX_OVFL];
  end
endmodule

// File: rtl/fpstat_accum.sv
module fpstat_accum
  import fpstat_pkg::*;
#(
  parameter logic [REG_W-1:0] CR_KEEP = 32'h0000_FFF0,
  parameter logic [REG_W-1:0] SR_KEEP = 32'h0FFF_FFF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_vld,
  input  logic             res_sign,
  input  logic [CLS_W-1:0] res_class,
  input  logic [EXC_W-1:0] res_exc,
  input  logic             cr_wr,
  input  logic             sr_wr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctl_reg,
  output logic [REG_W-1:0] sts_reg,
  output logic             trap_req
);
  localparam int unsigned ENB_LSB = EXC_LSB;

  logic             rst_meta, rst_n_s;
  logic [REG_W-1:0] sts_q, sts_d, ctl_q, ctl_d, upd_val;
  logic             sts_en, ctl_en;
  logic [CC_W-1:0]  cc_new;
  logic             snan_hit;
  logic [EXC_W-1:0] exc_new;
  logic [ACC_W-1:0] acc_set;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  fpstat_cc_gen u_cc (
    .sign_i (res_sign),
    .cls_i  (res_class),
    .cc_o   (cc_new),
    .snan_o (snan_hit)
  );

  always_comb begin
    exc_new          = res_exc;
    exc_new[EX_SNAN] = res_exc[EX_SNAN] | snan_hit;
  end

  fpstat_accrue u_acc (
    .exc_i     (exc_new),
    .acc_set_o (acc_set)
  );

  // next state
  always_comb begin
    upd_val                       = sts_q;
    upd_val[CC_LSB  +: CC_W]      = cc_new;
    upd_val[EXC_LSB +: EXC_W]     = exc_new;
    upd_val[ACC_LSB +: ACC_W]     = sts_q[ACC_LSB +: ACC_W] | acc_set;

    sts_en = sr_wr | res_vld;
    ctl_en = cr_wr;
    if (sr_wr) sts_d = wr_data & SR_KEEP;
    else       sts_d = upd_val & SR_KEEP;
    ctl_d = wr_data & CR_KEEP;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sts_q <= '0;
      ctl_q <= '0;
    end else begin
      if (sts_en) sts_q <= sts_d;
      if (ctl_en) ctl_q <= ctl_d;
    end
  end

  assign sts_reg  = sts_q;
  assign ctl_reg  = ctl_q;
  assign trap_req = |(sts_q[EXC_LSB +: EXC_W] & ctl_q[ENB_LSB +: EXC_W]);

  // checks
  AST_SR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sts_q & ~SR_KEEP) == '0); // R11
  AST_CR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_q & ~CR_KEEP) == '0); // R10
  AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && !sr_wr) |=> ((sts_q[ACC_LSB +: ACC_W] & $past(sts_q[ACC_LSB +: ACC_W]))
                             == $past(sts_q[ACC_LSB +: ACC_W]))); // R8
  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && !sr_wr) |=> $onehot0(sts_q[CC_LSB +: 3])); // R2
  AST_SNAN_BOTH: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && !sr_wr && res_class == CLS_SNAN) |=>
      (sts_q[CC_LSB + CC_NAN] && sts_q[EXC_LSB + EX_SNAN])); // R3
  AST_TRAP_RAISE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && !sr_wr && !cr_wr && ((res_exc & ctl_q[ENB_LSB +: EXC_W]) != '0)) |=> trap_req); // R9
  AST_SR_WINS: assert property (@(posedge clk) disable iff (!rst_n_s)
    sr_wr |=> (sts_q == ($past(wr_data) & SR_KEEP))); // R12
  AST_AUNFL_GATE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_vld && !sr_wr && !res_exc[EX_INEX2] && !sts_q[ACC_LSB + AC_UNFL]) |=>
      !sts_q[ACC_LSB + AC_UNFL]); // R6
endmodule

// File: tb/fpstat_accum_tb.sv
`timescale 1ns/1ps
module fpstat_accum_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_vld, res_sign, cr_wr, sr_wr;
  logic [2:0]  res_class;
  logic [7:0]  res_exc;
  logic [31:0] wr_data, ctl_reg, sts_reg;
  logic        trap_req;
  int          tests = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fpstat_accum u_dut (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_sign(res_sign),
    .res_class(res_class), .res_exc(res_exc), .cr_wr(cr_wr), .sr_wr(sr_wr),
    .wr_data(wr_data), .ctl_reg(ctl_reg), .sts_reg(sts_reg), .trap_req(trap_req)
  );

  // {seed, sign, class, exc, expected status}
  localparam int NV = 13;
  localparam logic [75:0] VEC [NV] = '{
    {32'h0000_0000, 1'b0, 3'd0, 8'h00, 32'h0000_0000},
    {32'h0000_0000, 1'b1, 3'd1, 8'h00, 32'h0C00_0000},
    {32'h0000_0000, 1'b0, 3'd2, 8'h10, 32'h0200_1048},
    {32'h0000_0000, 1'b0, 3'd4, 8'h00, 32'h0100_4080},
    {32'h0000_0000, 1'b1, 3'd3, 8'h00, 32'h0900_0000},
    {32'h0000_0000, 1'b0, 3'd0, 8'h08, 32'h0000_0800},
    {32'h0000_0000, 1'b0, 3'd0, 8'h0A, 32'h0000_0A28},
    {32'h0000_0000, 1'b1, 3'd2, 8'h04, 32'h0A00_0410},
    {32'h0000_0000, 1'b0, 3'd0, 8'h01, 32'h0000_0108},
    {32'h0000_0000, 1'b0, 3'd0, 8'h80, 32'h0000_8080},
    {32'h0000_0000, 1'b0, 3'd0, 8'h20, 32'h0000_2080},
    {32'h0E7F_F0F8, 1'b0, 3'd0, 8'h00, 32'h007F_00F8},
    {32'h0000_0000, 1'b0, 3'd1, 8'h02, 32'h0400_0208}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic [2:0] c, input logic [7:0] e,
                       input logic sw, input logic cw, input logic [31:0] d);
    @(negedge clk);
    res_vld = v; res_sign = s; res_class = c; res_exc = e;
    sr_wr = sw; cr_wr = cw; wr_data = d;
    @(negedge clk);
    res_vld = 0; sr_wr = 0; cr_wr = 0; res_exc = '0; res_class = '0; res_sign = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    res_vld = 0; res_sign = 0; res_class = '0; res_exc = '0;
    sr_wr = 0; cr_wr = 0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 status at reset", sts_reg, 32'h0);
    chk("R1 control at reset", ctl_reg, 32'h0);
    chk("R1 trap at reset", {31'b0, trap_req}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table: seed status, apply a result, compare (R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < NV; i++) begin
      drive(0, 0, 3'd0, 8'h00, 1, 0, VEC[i][75:44]);
      drive(1, VEC[i][43], VEC[i][42:40], VEC[i][39:32], 0, 0, 32'h0);
      chk($sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", i), sts_reg, VEC[i][31:0]);
    end

    // R10 / R11 masking of writes
    drive(0, 0, 3'd0, 8'h00, 0, 1, 32'hFFFF_FFFF);
    chk("R10 control write mask", ctl_reg, 32'h0000_FFF0);
    drive(0, 0, 3'd0, 8'h00, 1, 0, 32'hFFFF_FFFF);
    chk("R11 status write mask", sts_reg, 32'h0FFF_FFF8);
    chk("R9 trap with all enabled", {31'b0, trap_req}, 32'h1);

    // R9 trap only on an enabled flag
    drive(0, 0, 3'd0, 8'h00, 0, 1, 32'h0000_0400);
    drive(0, 0, 3'd0, 8'h00, 1, 0, 32'h0);
    drive(1, 0, 3'd0, 8'h10, 0, 0, 32'h0);
    chk("R9 disabled flag no trap", {31'b0, trap_req}, 32'h0);
    drive(1, 0, 3'd0, 8'h04, 0, 0, 32'h0);
    chk("R9 enabled flag traps", {31'b0, trap_req}, 32'h1);
    drive(1, 0, 3'd0, 8'h00, 0, 0, 32'h0);
    chk("R4 exception byte cleared drops trap", {31'b0, trap_req}, 32'h0);
    chk("R8 accrued kept after clean op", sts_reg, 32'h0000_0058);
    drive(1, 0, 3'd0, 8'h04, 0, 0, 32'h0);
    drive(0, 0, 3'd0, 8'h00, 0, 1, 32'h0);
    chk("R9 trap drops with enable cleared", {31'b0, trap_req}, 32'h0);

    // R12 collisions
    drive(0, 0, 3'd0, 8'h00, 1, 0, 32'h0);
    drive(1, 0, 3'd1, 8'h04, 1, 0, 32'h1234_5678);
    chk("R12 status write beats result", sts_reg, 32'h0234_5678);
    drive(0, 0, 3'd0, 8'h00, 1, 0, 32'h0);
    drive(1, 0, 3'd1, 8'h00, 0, 1, 32'h0000_AB00);
    chk("R12 result with control write: status", sts_reg, 32'h0400_0000);
    chk("R12 result with control write: control", ctl_reg, 32'h0000_AB00);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset status", sts_reg, 32'h0);
    chk("R1 mid-run reset control", ctl_reg, 32'h0);
    do_reset();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule